// File: doc/BRIEF.md
# Tagged Receive Character Queue

This block is the per-channel receive buffer that sits behind a UART receiver. Each character arrives with four line-condition tags (break, framing error, overrun, parity error). The block keeps the character and its tags together as one entry and holds up to 512 entries in arrival order. The host side pops one tagged entry per read. A live count of stored entries is always visible. The block raises a receive-data interrupt request when the count reaches a selectable trigger level.

The write side is a valid/ready stream. `in_ready` is low only when the queue is full. The receiver cannot stall, so a character offered while `in_ready` is low is not kept. Instead, the entry stored most recently gets its overrun tag set. The read side is also a valid/ready stream. `out_valid` is high whenever an entry is stored, and a cycle with `out_ready` high pops the head entry. `out_data` reads zero while the queue is empty. A held flush control empties the queue. Plain inputs select the trigger level and gate the interrupt.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: Entries leave in arrival order. Capacity is 512 entries. A popped entry carries the character in bits 7:0, parity error in bit 8, overrun in bit 9, framing error in bit 10 and break in bit 11. `in_flags` uses the same order: bit 0 parity, bit 1 overrun, bit 2 framing, bit 3 break.
- R2: `fill_count` is exact in the cycle after each accepted push or pop. A push and a pop accepted in the same cycle leave it unchanged.
- R3: When 512 entries are stored, `in_ready` is low. A character offered then is dropped, and the count stays at 512 unless a pop is accepted.
- R4: A dropped character sets bit 9 (overrun) of the most recently stored entry. The data and the other tags of that entry are unchanged.
- R5: With the queue empty, `out_valid` is low and `out_data` is zero. A pop request does not change the count.
- R6: `trig_sel` value 1 raises `rx_irq` at 1 or more entries, value 2 at 256 or more, and value 3 at 448 or more. `rx_irq` follows the count in the same cycle.
- R7: `trig_sel` value 0 keeps `rx_irq` low at any fill level.
- R8: `rx_irq` is high only while both `rx_enable` and `irq_enable` are high.
- R9: While `flush` is high, the queue is empty one cycle later and pushes are not stored. Normal operation resumes in the cycle after `flush` is released.
- R10: After reset, the count is zero, `out_valid` and `rx_irq` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Receiver offers a character |
| in_ready | output | 1 | Queue has room; low when full |
| in_data | input | 8 | Received character |
| in_flags | input | 4 | Tags: bit0 parity, bit1 overrun, bit2 framing, bit3 break |
| out_valid | output | 1 | At least one entry stored |
| out_ready | input | 1 | Pop the head entry this cycle |
| out_data | output | 12 | Head entry (tags in 11:8, character in 7:0), zero when empty |
| fill_count | output | 10 | Number of stored entries (0 to 512) |
| flush | input | 1 | Empty the queue while high |
| rx_enable | input | 1 | Receive enabled |
| irq_enable | input | 1 | Receive interrupt enabled |
| trig_sel | input | 2 | Trigger level: 0 off, 1 one entry, 2 256 entries, 3 448 entries |
| rx_irq | output | 1 | Receive-data interrupt request |

## Verification
`fill_count`, `in_ready`, `out_valid` and `out_data` are registered results. They are due one clock edge after the push, pop or flush that causes them. `rx_irq` is decoded from the count register and the plain controls. It therefore changes in the same cycle as the count, and at once after a change to `trig_sel`, `rx_enable` or `irq_enable`. The bench changes inputs on the falling edge and samples on the next falling edge, so each sample sees exactly one rising edge of effect. For the overrun tag, the bench pops the queue down to the marked entry and checks it at the output.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int FLAG_W = 4;
  // tag order inside the flag nibble
  localparam int TAG_PAR = 0;
  localparam int TAG_OVR = 1;
  localparam int TAG_FRM = 2;
  localparam int TAG_BRK = 3;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_ONE  = 2'd1,
    TRIG_MID  = 2'd2,
    TRIG_HIGH = 2'd3
  } trig_sel_e;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 512,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic             flush,
  output logic             push_acc,
  output logic             pop_acc,
  output logic             mark_ovr,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  assign empty    = (count == '0);
  assign full     = (count == FULL_CNT);
  assign push_acc = in_valid && !full && !flush;
  assign pop_acc  = out_ready && !empty && !flush;
  assign mark_ovr = in_valid && full && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (flush) begin
      count <= '0;
    end else begin
      case ({push_acc, pop_acc})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  assert_drop_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid && !out_ready && !flush) |=> (count == FULL_CNT));
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && pop_acc) |=> $stable(count));
  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !in_valid) |=> (count == '0));
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH   = 512,
  parameter int ENT_W   = 12,
  parameter int OVR_POS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic             mark,
  input  logic [ENT_W-1:0] wr_entry,
  output logic [ENT_W-1:0] head
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [PTR_W-1:0] newest;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign newest = (wptr == '0) ? LAST_IDX : wptr - 1'b1;
  assign head   = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) wptr <= step_ptr(wptr);
      if (pop)  rptr <= step_ptr(rptr);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_entry;
    if (mark) mem[newest][OVR_POS] <= 1'b1;
  end

  assert_no_mark_on_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mark && push));
endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger
  import rxq_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int LVL_MID  = 256,
  parameter int LVL_HIGH = 448
) (
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       trig_sel,
  input  logic             rx_enable,
  input  logic             irq_enable,
  output logic             irq
);
  trig_sel_e        sel;
  logic [CNT_W-1:0] level;
  logic             reached;

  assign sel = trig_sel_e'(trig_sel);

  always_comb begin
    level   = '0;
    reached = 1'b0;
    case (sel)
      TRIG_ONE:  begin level = CNT_W'(1);        reached = (count >= level); end
      TRIG_MID:  begin level = CNT_W'(LVL_MID);  reached = (count >= level); end
      TRIG_HIGH: begin level = CNT_W'(LVL_HIGH); reached = (count >= level); end
      default:   begin level = '0;               reached = 1'b0;             end
    endcase
  end

  assign irq = rx_enable && irq_enable && reached;
endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo
  import rxq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 512,
  parameter int LVL_MID  = 256,
  parameter int LVL_HIGH = 448,
  localparam int ENT_W   = DATA_W + FLAG_W,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ENT_W-1:0]  out_data,
  output logic [CNT_W-1:0]  fill_count,
  input  logic              flush,
  input  logic              rx_enable,
  input  logic              irq_enable,
  input  logic [1:0]        trig_sel,
  output logic              rx_irq
);
  logic             push_acc, pop_acc, mark_ovr, full, empty;
  logic [ENT_W-1:0] head;

  rxq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .flush(flush), .push_acc(push_acc), .pop_acc(pop_acc), .mark_ovr(mark_ovr),
    .full(full), .empty(empty), .count(fill_count)
  );

  rxq_store #(.DEPTH(DEPTH), .ENT_W(ENT_W), .OVR_POS(DATA_W + TAG_OVR)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_acc), .pop(pop_acc), .flush(flush),
    .mark(mark_ovr), .wr_entry({in_flags, in_data}), .head(head)
  );

  rxq_trigger #(.CNT_W(CNT_W), .LVL_MID(LVL_MID), .LVL_HIGH(LVL_HIGH)) u_trig (
    .count(fill_count), .trig_sel(trig_sel), .rx_enable(rx_enable),
    .irq_enable(irq_enable), .irq(rx_irq)
  );

  assign in_ready  = !full;
  assign out_valid = !empty;
  assign out_data  = empty ? '0 : head;

  assert_empty_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));
  assert_trig_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_enable && irq_enable && trig_sel == 2'd1 && out_valid) |-> rx_irq);
  assert_trig_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel == 2'd0) |-> !rx_irq);
  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (rx_enable && irq_enable && out_valid));
  assert_ready_tracks_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);
endmodule

// File: tb/test_rxq_tagged_fifo.sv
`timescale 1ns/1ps
module test_rxq_tagged_fifo;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [7:0]  in_data;
  logic [3:0]  in_flags;
  logic [11:0] out_data;
  logic [9:0]  fill_count;
  logic        flush, rx_enable, irq_enable, rx_irq;
  logic [1:0]  trig_sel;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  rxq_tagged_fifo i_rxq_tagged_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_flags(in_flags), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .fill_count(fill_count),
    .flush(flush), .rx_enable(rx_enable), .irq_enable(irq_enable),
    .trig_sel(trig_sel), .rx_irq(rx_irq)
  );

  // {push, pop, data, flags, count after, head after, irq after}
  localparam logic [36:0] VEC [0:8] = '{
    {1'b1, 1'b0, 8'hA5, 4'h0, 10'd1, 12'h0A5, 1'b1},
    {1'b1, 1'b0, 8'h3C, 4'h1, 10'd2, 12'h0A5, 1'b1},
    {1'b1, 1'b1, 8'h7E, 4'h4, 10'd2, 12'h13C, 1'b1},
    {1'b0, 1'b1, 8'h00, 4'h0, 10'd1, 12'h47E, 1'b1},
    {1'b1, 1'b0, 8'h00, 4'h8, 10'd2, 12'h47E, 1'b1},
    {1'b0, 1'b1, 8'h00, 4'h0, 10'd1, 12'h800, 1'b1},
    {1'b0, 1'b1, 8'h00, 4'h0, 10'd0, 12'h000, 1'b0},
    {1'b0, 1'b1, 8'h00, 4'h0, 10'd0, 12'h000, 1'b0},
    {1'b1, 1'b0, 8'hFF, 4'h2, 10'd1, 12'h2FF, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_run(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = 8'(base + i);
      in_flags = 4'h0;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic pop_run(input int n);
    for (int i = 0; i < n; i++) begin
      out_ready = 1'b1;
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = '0; in_flags = '0;
    flush = 1'b0; rx_enable = 1'b1; irq_enable = 1'b1; trig_sel = 2'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 count", fill_count, 0);
    chk("R10 out_valid", out_valid, 0);
    chk("R10 in_ready", in_ready, 1);
    chk("R10 irq", rx_irq, 0);

    // R1 R2 R5 R6 table walk
    for (int v = 0; v < 9; v++) begin
      in_valid  = VEC[v][36];
      out_ready = VEC[v][35];
      in_data   = VEC[v][34:27];
      in_flags  = VEC[v][26:23];
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b0;
      chk("R2 table count", fill_count, int'(VEC[v][22:13]));
      chk("R1 table head", out_data, int'(VEC[v][12:1]));
      chk("R6 table irq", rx_irq, int'(VEC[v][0]));
    end
    pop_run(1);
    chk("R5 empty zero", out_data, 0);

    // R6 mid and high levels
    trig_sel = 2'd2;
    push_run(255, 0);
    chk("R6 mid below", rx_irq, 0);
    push_run(1, 255);
    chk("R6 mid reached", rx_irq, 1);
    trig_sel = 2'd3;
    #1 chk("R6 high below", rx_irq, 0);
    push_run(191, 256);
    chk("R6 count 447", fill_count, 447);
    chk("R6 high below 447", rx_irq, 0);
    push_run(1, 447);
    chk("R6 high reached", rx_irq, 1);
    push_run(64, 448);
    chk("R3 full count", fill_count, 512);
    chk("R3 in_ready low", in_ready, 0);
    chk("R1 oldest head", out_data, 12'h000);

    // R7 R8 gating
    trig_sel = 2'd0;
    #1 chk("R7 off", rx_irq, 0);
    trig_sel = 2'd3; rx_enable = 1'b0;
    #1 chk("R8 rx disabled", rx_irq, 0);
    rx_enable = 1'b1; irq_enable = 1'b0;
    #1 chk("R8 irq disabled", rx_irq, 0);
    irq_enable = 1'b1;

    // R3 R4 drop while full
    in_valid = 1'b1; in_data = 8'h11; in_flags = 4'h0;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3 drop count", fill_count, 512);
    pop_run(511);
    chk("R4 last count", fill_count, 1);
    chk("R4 overrun tag", out_data, 12'h2FF);
    pop_run(1);
    chk("R5 drained", out_valid, 0);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R5 empty pop count", fill_count, 0);

    // R9 flush
    push_run(3, 8'h40);
    chk("R9 pre count", fill_count, 3);
    flush = 1'b1; in_valid = 1'b1; in_data = 8'h77;
    repeat (2) @(negedge clk);
    chk("R9 flushed", fill_count, 0);
    chk("R9 flushed valid", out_valid, 0);
    flush = 1'b0; in_data = 8'h5A;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 resume count", fill_count, 1);
    chk("R9 resume head", out_data, 12'h05A);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule